// File: doc/BRIEF.md
# Serial Register Write Master

This block sits on the host side of a three-wire serial link and produces complete register write frames for a slave device. A request supplies a 24-bit data word, a 5-bit register address and a 3-bit chip address, and it is taken in over a valid/ready handshake. The block divides the system clock to make the serial clock and shifts out 32 bits. The data word goes first, then the register address, then the chip address, and each field starts with its most significant bit.

The serial clock idles low. A new bit is presented on the data line while the clock is low, and the slave samples it on the next rising edge. After the 32nd rising edge the clock returns low and the block raises the enable line as an active-high commit strobe. It holds the strobe high for a set number of system clocks, lowers it, and waits out a recovery interval. It then pulses `done` for one clock and accepts the next request. The clock divider, the strobe width and the recovery time are parameters counted in system clocks. Choose them so the serial clock stays at or below 50 MHz and the slave's setup, hold and enable timing are met.

Top module: `serial_write_master`

## Requirements
- R1: While reset is asserted and on leaving it, `sclk`, `sen` and `done` are low and `req_ready` is high.
- R2: Each frame carries `{req_data, req_reg, req_chip}` as 32 bits, most significant bit first: data bit 23 on the first rising edge, then register bits 4 to 0, and chip bit 0 on the 32nd.
- R3: `sdi` changes only while `sclk` is low, so it is stable across every rising edge of `sclk`.
- R4: Every frame has exactly 32 rising edges of `sclk`, and `sen` is low during all of them.
- R5: `sclk` stays high for exactly `HALF_DIV` system clocks, and stays low for the same time between rising edges within a frame.
- R6: `sen` rises only after the 32nd rising edge, with `sclk` already low, and stays high for exactly `SEN_HIGH` system clocks.
- R7: `sdi` keeps the last chip-address bit for as long as `sen` is high.
- R8: `req_ready` falls on the clock that accepts a request and stays low through the frame. `done` is a one-clock pulse that comes exactly `RECOVER` clocks after `sen` falls, and `req_ready` rises with it.
- R9: Request inputs presented while `req_ready` is low are ignored and have no effect on the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_data | input | 24 | Data word to write |
| req_reg | input | 5 | Target register address |
| req_chip | input | 3 | Target chip address |
| sclk | output | 1 | Serial clock, idles low |
| sdi | output | 1 | Serial data to the slave |
| sen | output | 1 | Active-high commit strobe |
| done | output | 1 | One-clock completion pulse |

## Verification
The bench builds the block with `HALF_DIV` = 2, `SEN_HIGH` = 3 and `RECOVER` = 4. With these values the serial clock runs at a quarter of the system clock, and the strobe width and recovery time have different lengths. An error that swaps the two counts, or that is off by one clock in either, therefore changes a measured count. The bench sends several frames with all-ones, all-zeros, alternating and walking-bit fields. It also sends back-to-back requests, and during one frame it holds a conflicting request on the inputs to check that it is ignored.

// File: rtl/serial_write_master.sv
module serial_write_master #(
  parameter int DATA_W   = 24,
  parameter int REG_W    = 5,
  parameter int CHIP_W   = 3,
  parameter int HALF_DIV = 2,
  parameter int SEN_HIGH = 2,
  parameter int RECOVER  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [DATA_W-1:0] req_data,
  input  logic [REG_W-1:0]  req_reg,
  input  logic [CHIP_W-1:0] req_chip,
  output logic              sclk,
  output logic              sdi,
  output logic              sen,
  output logic              done
);

  localparam int FRAME_W = DATA_W + REG_W + CHIP_W;
  localparam int NB_W    = $clog2(FRAME_W + 1);
  localparam int CMAX    = (HALF_DIV > SEN_HIGH) ?
                           ((HALF_DIV > RECOVER) ? HALF_DIV : RECOVER) :
                           ((SEN_HIGH > RECOVER) ? SEN_HIGH : RECOVER);
  localparam int CNT_W   = $clog2(CMAX + 1);

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_COMMIT, S_RECOV} state_t;

  state_t             state;
  logic [FRAME_W-1:0] shreg;
  logic [NB_W-1:0]    nbits;
  logic [CNT_W-1:0]   cnt;

  assign req_ready = (state == S_IDLE);
  assign sdi       = shreg[FRAME_W-1];

  wire accept   = req_valid && req_ready;
  wire half_end = (cnt == CNT_W'(HALF_DIV - 1));
  wire last_bit = (nbits == NB_W'(FRAME_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      shreg <= '0;
      nbits <= '0;
      cnt   <= '0;
      sclk  <= 1'b0;
      sen   <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        S_IDLE: if (accept) begin
          shreg <= {req_data, req_reg, req_chip};
          nbits <= '0;
          cnt   <= '0;
          state <= S_SHIFT;
        end
        S_SHIFT: if (!half_end) begin
          cnt <= cnt + 1'b1;
        end else begin
          cnt <= '0;
          if (!sclk) begin
            sclk  <= 1'b1;
            nbits <= nbits + 1'b1;
          end else begin
            sclk <= 1'b0;
            if (last_bit) begin
              sen   <= 1'b1;
              state <= S_COMMIT;
            end else begin
              shreg <= shreg << 1;
            end
          end
        end
        S_COMMIT: if (cnt == CNT_W'(SEN_HIGH - 1)) begin
          sen   <= 1'b0;
          cnt   <= '0;
          state <= S_RECOV;
        end else begin
          cnt <= cnt + 1'b1;
        end
        S_RECOV: if (cnt == CNT_W'(RECOVER - 1)) begin
          done  <= 1'b1;
          cnt   <= '0;
          state <= S_IDLE;
        end else begin
          cnt <= cnt + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/serial_write_master_chk.sv
module serial_write_master_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic sclk,
  input logic sdi,
  input logic sen,
  input logic done
);

  assert_sdi_steady_at_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $stable(sdi));

  assert_sen_with_sclk_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sen |-> !sclk);

  assert_sdi_held_in_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sen && $past(sen)) |-> $stable(sdi));

  assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_not_ready_in_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sen |-> !req_ready);

  always_comb begin
    if (!rst_n) begin
      assert_reset_outputs_R1: assert (!sclk && !sen && !done && req_ready);
    end
  end

endmodule

bind serial_write_master serial_write_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .sclk(sclk), .sdi(sdi), .sen(sen), .done(done)
);

// File: tb/serial_write_master_bench.sv
module serial_write_master_bench;
  localparam int HALF = 2;
  localparam int SENH = 3;
  localparam int REC  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [23:0] req_data = '0;
  logic [4:0]  req_reg = '0;
  logic [2:0]  req_chip = '0;
  logic sclk, sdi, sen, done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [31:0] exp_q[$];

  always #10 clk = ~clk;

  serial_write_master #(.HALF_DIV(HALF), .SEN_HIGH(SENH), .RECOVER(REC)) u_serial_write_master (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_data(req_data), .req_reg(req_reg), .req_chip(req_chip),
    .sclk(sclk), .sdi(sdi), .sen(sen), .done(done));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic [23:0] d, input logic [4:0] r, input logic [2:0] c);
    @(negedge clk);
    req_data = d; req_reg = r; req_chip = c; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    exp_q.push_back({d, r, c});
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!req_ready);
  endtask

  // monitor
  logic prev_sclk = 0, prev_sen = 0, prev_sdi = 0, prev_done = 0, in_rec = 0;
  int hi_len = 0, sen_len = 0, rec_cnt = 0, nrise = 0, rdy_bad = 0;
  logic [31:0] cap = '0, cur = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (sclk && !prev_sclk) begin
        check(sdi == prev_sdi, "R3", 32'(sdi), 32'(prev_sdi));
        check(!sen, "R4", 32'(sen), 32'd0);
        cap = {cap[30:0], sdi};
        nrise++;
      end
      if (sclk) hi_len++;
      if (!sclk && prev_sclk) begin
        check(hi_len == HALF, "R5", 32'(hi_len), 32'(HALF));
        hi_len = 0;
      end
      if ((nrise > 0 || sen || in_rec) && req_ready && !done) rdy_bad++;
      if (sen && !prev_sen) begin
        check(nrise == 32, "R4", 32'(nrise), 32'd32);
        check(!sclk, "R6", 32'(sclk), 32'd0);
        if (exp_q.size() == 0) begin
          check(1'b0, "R9", cap, 32'd0);
          cur = '0;
        end else begin
          cur = exp_q.pop_front();
          check(cap == cur, "R2", cap, cur);
        end
      end
      if (sen) begin
        sen_len++;
        check(sdi == cur[0], "R7", 32'(sdi), 32'(cur[0]));
      end
      if (in_rec) rec_cnt++;
      if (!sen && prev_sen) begin
        check(sen_len == SENH, "R6", 32'(sen_len), 32'(SENH));
        sen_len = 0; in_rec = 1; rec_cnt = 0;
      end
      if (done) begin
        check(in_rec && rec_cnt == REC, "R8", 32'(rec_cnt), 32'(REC));
        check(rdy_bad == 0 && req_ready, "R8", 32'(rdy_bad), 32'd0);
        in_rec = 0; nrise = 0; rdy_bad = 0;
      end
      if (done && prev_done) check(1'b0, "R8", 32'd1, 32'd0);
      prev_sclk = sclk; prev_sen = sen; prev_sdi = sdi; prev_done = done;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!sclk && !sen && !done && req_ready, "R1", {28'd0, sclk, sen, done, req_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check(!sclk && !sen && !done && req_ready, "R1", {28'd0, sclk, sen, done, req_ready}, 32'd1);

    send(24'hFFFFFF, 5'h1F, 3'h7); wait_idle();
    send(24'h000000, 5'h00, 3'h0); wait_idle();
    send(24'hA5A5A5, 5'h15, 3'h5); wait_idle();
    // R9: conflicting request held while busy
    send(24'h800001, 5'h10, 3'h1);
    repeat (10) @(negedge clk);
    req_valid = 1'b1; req_data = 24'h123456; req_reg = 5'h0A; req_chip = 3'h6;
    repeat (40) @(negedge clk);
    check(!req_ready, "R9", 32'(req_ready), 32'd0);
    req_valid = 1'b0;
    wait_idle();
    repeat (5) @(negedge clk);
    check(exp_q.size() == 0 && !sen && !sclk, "R9", 32'(exp_q.size()), 32'd0);
    // back-to-back
    send(24'h5A5A5A, 5'h0B, 3'h2);
    send(24'h000001, 5'h01, 3'h4);
    wait_idle();
    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "R2", 32'(exp_q.size()), 32'd0);

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule